// File: doc/BRIEF.md
# Descriptor Ring Controller

This block keeps a table of 128 descriptors in flops. Each descriptor holds two 32-bit words: a length-and-flags word at the even word index and a buffer pointer at the odd word index. The host sees the table as a 1 KB window of 256 words and addresses it by word index. A movable boundary N splits the table. Descriptors below N form the transmit ring. Descriptors from N to 127 form the receive ring.

On the transmit side the block decides when a frame may begin, then pulses `tx_start` with the current descriptor's length and pointer. When the data mover answers on `tx_done`, the block retires the descriptor and advances its index. On the receive side a frame arrives as a one-cycle `rx_req` carrying its length. The block either fills the current receive descriptor or drops the frame and flags the drop. Completion events and drops set bits in an interrupt source register. Those bits are cleared by writing 1 to them. The register is gated by a mask onto one interrupt line.

Control writes go through a small port. The selector codes are: 0 writes the boundary, 1 clears source bits, and 2 writes the mask.

Top module: `bd_ring_ctrl`

## Requirements
- R1: After reset the boundary is 64 and the transmit index is 0. The receive index is 64, the source and mask registers are 0, `irq` is low and every table word reads 0.
- R2: A boundary write whose data is 128 or more is ignored. Smaller values are taken.
- R3: A transmit check runs one cycle after any host write into the table, or after a rising edge of `txen`, and only then. It pulses `tx_start` when all of the following hold: `txen` is high, N is above 0, ready flag bit 15 is set, and the length field (bits 31:16) is above 4.
- R4: After `tx_start`, no further start occurs until `tx_done` retires the frame.
- R5: On `tx_done`, flag bits 15, 8 and 7:0 of the descriptor are cleared. The length and flag bits 14:9 are kept.
- R6: After a retire the transmit index goes to 0 if wrap flag bit 13 was set. Otherwise it increments, and it becomes 0 when the result reaches N.
- R7: A frame arriving while the current receive descriptor has empty flag bit 15 clear is dropped. The descriptor and the receive index stay unchanged, and source bit 4 is set.
- R8: An accepted frame writes its length into bits 31:16 and clears flag bits 15 and 8:0. The receive index then returns to N if wrap bit 13 is set or the index is 127, and otherwise increments.
- R9: A retired or filled descriptor with bit 14 set raises source bit 0 (transmit) or source bit 1 (receive).
- R10: A source-clear write clears exactly the bits written as 1. `irq` is high whenever source AND mask is nonzero.
- R11: A rising edge of `rxen` sets the receive index to N. A rising edge of `txen` sets the transmit index to 0.
- R12: While `rxen` is low, `rx_req` has no effect on the table, the receive index or the source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txen | input | 1 | Transmit enable |
| rxen | input | 1 | Receive enable |
| hw_en | input | 1 | Host table write strobe |
| hw_addr | input | 8 | Host write word index |
| hw_data | input | 32 | Host write data |
| hr_addr | input | 8 | Host read word index |
| hr_data | output | 32 | Host read data |
| cfg_we | input | 1 | Control write strobe |
| cfg_sel | input | 2 | Control target: 0 boundary, 1 source clear, 2 mask |
| cfg_wdata | input | 32 | Control write data |
| boundary | output | 8 | Ring split point N |
| int_src | output | 5 | Interrupt source bits |
| int_mask | output | 5 | Interrupt mask bits |
| irq | output | 1 | Interrupt line |
| tx_start | output | 1 | One-cycle transmit start pulse |
| tx_idx | output | 7 | Current transmit descriptor |
| tx_len | output | 16 | Length of the current transmit descriptor |
| tx_ptr | output | 32 | Buffer pointer of the current transmit descriptor |
| tx_done | input | 1 | Frame sent by the data mover |
| rx_req | input | 1 | Frame arrived |
| rx_len | input | 16 | Length of the arriving frame |
| rx_idx | output | 7 | Current receive descriptor |
| rx_ptr | output | 32 | Buffer pointer of the current receive descriptor |

## Verification
The bench targets the length threshold at 4 and 5 and a ready descriptor with N at 0. A design with an off-by-one compare, or one that ignores N, would send a runt frame or transmit from an empty ring. It also probes index 127 and a wrap flag on the first receive descriptor, so that a receive ring running past the table end or skipping back incorrectly shows up as a wrong `rx_idx`. It confirms that a retire alone does not start the next ready descriptor, which a design that polls every cycle would do. It also writes 1 to one source bit at a time, which exposes a clear that wipes the whole register.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

    // Flag bit positions inside the low half of a length/flags word
    localparam int F_OWN   = 15;   // ready (tx) / empty (rx)
    localparam int F_IRQ   = 14;
    localparam int F_WRAP  = 13;

    // Status bits cleared when a descriptor is retired or filled
    localparam logic [15:0] STAT_CLR = 16'h81FF;

    // Interrupt source layout
    localparam int SRC_W    = 5;
    localparam int SRC_TX   = 0;
    localparam int SRC_RX   = 1;
    localparam int SRC_BUSY = 4;

    localparam int LEN_MIN_EXCL = 4;

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] flags;
    } lf_t;

    typedef enum logic [1:0] {
        CFG_BOUNDARY = 2'd0,
        CFG_SRC_CLR  = 2'd1,
        CFG_MASK     = 2'd2
    } cfg_sel_e;

    function automatic lf_t retire_tx(input lf_t d);
        lf_t r;
        r.len   = d.len;
        r.flags = d.flags & ~STAT_CLR;
        return r;
    endfunction

    function automatic lf_t fill_rx(input lf_t d, input logic [15:0] len);
        lf_t r;
        r.len   = len;
        r.flags = d.flags & ~STAT_CLR;
        return r;
    endfunction

endpackage

// File: rtl/bdr_table.sv
module bdr_table #(
    parameter int DESC_COUNT = 128,
    localparam int IDX_W   = $clog2(DESC_COUNT),
    localparam int WORDS   = 2 * DESC_COUNT,
    localparam int WADDR_W = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_we,
    input  logic [WADDR_W-1:0] h_waddr,
    input  logic [31:0]        h_wdata,
    input  logic [WADDR_W-1:0] h_raddr,
    output logic [31:0]        h_rdata,
    input  logic [IDX_W-1:0]   t_idx,
    input  logic               t_we,
    input  logic [31:0]        t_wdata,
    output logic [31:0]        t_lf,
    output logic [31:0]        t_ptr,
    input  logic [IDX_W-1:0]   r_idx,
    input  logic               r_we,
    input  logic [31:0]        r_wdata,
    output logic [31:0]        r_lf,
    output logic [31:0]        r_ptr
);
    logic [31:0] mem [WORDS];

    // Later assignments win: engine updates override a host write to the same word
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            if (h_we) mem[h_waddr] <= h_wdata;
            if (t_we) mem[{t_idx, 1'b0}] <= t_wdata;
            if (r_we) mem[{r_idx, 1'b0}] <= r_wdata;
        end
    end

    assign h_rdata = mem[h_raddr];
    assign t_lf    = mem[{t_idx, 1'b0}];
    assign t_ptr   = mem[{t_idx, 1'b1}];
    assign r_lf    = mem[{r_idx, 1'b0}];
    assign r_ptr   = mem[{r_idx, 1'b1}];
endmodule

// File: rtl/bdr_tx_ctrl.sv
module bdr_tx_ctrl
    import bdr_pkg::*;
#(
    parameter int DESC_COUNT = 128,
    localparam int IDX_W = $clog2(DESC_COUNT),
    localparam int BND_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             txen,
    input  logic             table_wr,
    input  logic             tx_done,
    input  logic [BND_W-1:0] boundary,
    input  lf_t              cur_lf,
    output logic [IDX_W-1:0] idx,
    output logic             start,
    output logic             upd_we,
    output lf_t              upd_lf,
    output logic             done_set
);
    logic txen_q, busy, pend;
    logic rise, eval, can_go, go, retire;
    logic [BND_W-1:0] inc;
    logic [IDX_W-1:0] nxt;

    assign rise   = txen && !txen_q;
    assign can_go = txen && (boundary != '0) && cur_lf.flags[F_OWN]
                    && (cur_lf.len > 16'(LEN_MIN_EXCL));
    assign eval   = !busy && pend && !rise;
    assign go     = eval && can_go;
    assign retire = busy && tx_done;

    assign inc = {1'b0, idx} + 1'b1;
    assign nxt = (cur_lf.flags[F_WRAP] || inc >= boundary) ? '0 : inc[IDX_W-1:0];

    assign upd_we   = retire;
    assign upd_lf   = retire_tx(cur_lf);
    assign done_set = retire && cur_lf.flags[F_IRQ];

    always_ff @(posedge clk) begin
        if (rst) begin
            txen_q <= 1'b0;
            busy   <= 1'b0;
            pend   <= 1'b0;
            start  <= 1'b0;
            idx    <= '0;
        end else begin
            txen_q <= txen;
            start  <= go;
            pend   <= rise || table_wr || (pend && !eval);
            if (go)          busy <= 1'b1;
            else if (retire) busy <= 1'b0;
            if (rise)        idx <= '0;
            else if (retire) idx <= nxt;
        end
    end
endmodule

// File: rtl/bdr_rx_ctrl.sv
module bdr_rx_ctrl
    import bdr_pkg::*;
#(
    parameter int DESC_COUNT = 128,
    localparam int IDX_W = $clog2(DESC_COUNT),
    localparam int BND_W = IDX_W + 1,
    localparam logic [IDX_W-1:0] IDX_RST = IDX_W'(DESC_COUNT / 2),
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_COUNT - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxen,
    input  logic             rx_req,
    input  logic [15:0]      rx_len,
    input  logic [BND_W-1:0] boundary,
    input  lf_t              cur_lf,
    output logic [IDX_W-1:0] idx,
    output logic             upd_we,
    output lf_t              upd_lf,
    output logic             done_set,
    output logic             busy_set
);
    logic rxen_q, rise, take, fill;
    logic [IDX_W-1:0] nxt;

    assign rise = rxen && !rxen_q;
    assign take = rx_req && rxen;
    assign fill = take && cur_lf.flags[F_OWN];

    assign nxt = (cur_lf.flags[F_WRAP] || idx == IDX_LAST)
                 ? boundary[IDX_W-1:0] : idx + 1'b1;

    assign upd_we   = fill;
    assign upd_lf   = fill_rx(cur_lf, rx_len);
    assign done_set = fill && cur_lf.flags[F_IRQ];
    assign busy_set = take && !cur_lf.flags[F_OWN];

    always_ff @(posedge clk) begin
        if (rst) begin
            rxen_q <= 1'b0;
            idx    <= IDX_RST;
        end else begin
            rxen_q <= rxen;
            if (rise)      idx <= boundary[IDX_W-1:0];
            else if (fill) idx <= nxt;
        end
    end
endmodule

// File: rtl/bdr_irq.sv
module bdr_irq
    import bdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] set_vec,
    input  logic             clr_we,
    input  logic [SRC_W-1:0] clr_vec,
    input  logic             mask_we,
    input  logic [SRC_W-1:0] mask_val,
    output logic [SRC_W-1:0] src,
    output logic [SRC_W-1:0] mask,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            src  <= '0;
            mask <= '0;
        end else begin
            src <= (src & ~(clr_we ? clr_vec : '0)) | set_vec;
            if (mask_we) mask <= mask_val;
        end
    end

    assign irq = |(src & mask);
endmodule

// File: rtl/bd_ring_ctrl.sv
module bd_ring_ctrl
    import bdr_pkg::*;
#(
    parameter int DESC_COUNT = 128,
    localparam int IDX_W   = $clog2(DESC_COUNT),
    localparam int BND_W   = IDX_W + 1,
    localparam int WADDR_W = $clog2(2 * DESC_COUNT),
    localparam logic [BND_W-1:0] BND_RST = BND_W'(DESC_COUNT / 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               txen,
    input  logic               rxen,
    input  logic               hw_en,
    input  logic [WADDR_W-1:0] hw_addr,
    input  logic [31:0]        hw_data,
    input  logic [WADDR_W-1:0] hr_addr,
    output logic [31:0]        hr_data,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    output logic [BND_W-1:0]   boundary,
    output logic [SRC_W-1:0]   int_src,
    output logic [SRC_W-1:0]   int_mask,
    output logic               irq,
    output logic               tx_start,
    output logic [IDX_W-1:0]   tx_idx,
    output logic [15:0]        tx_len,
    output logic [31:0]        tx_ptr,
    input  logic               tx_done,
    input  logic               rx_req,
    input  logic [15:0]        rx_len,
    output logic [IDX_W-1:0]   rx_idx,
    output logic [31:0]        rx_ptr
);
    cfg_sel_e sel;
    lf_t t_lf, r_lf, t_upd, r_upd;
    logic [31:0] t_lf_w, r_lf_w;
    logic t_we, r_we, t_irq, r_irq, r_busy;
    logic [SRC_W-1:0] set_vec;

    assign sel = cfg_sel_e'(cfg_sel);

    // Boundary: out-of-range values are dropped
    always_ff @(posedge clk) begin
        if (rst) boundary <= BND_RST;
        else if (cfg_we && sel == CFG_BOUNDARY && cfg_wdata < 32'(DESC_COUNT))
            boundary <= cfg_wdata[BND_W-1:0];
    end

    assign t_lf   = lf_t'(t_lf_w);
    assign r_lf   = lf_t'(r_lf_w);
    assign tx_len = t_lf.len;

    bdr_table #(.DESC_COUNT(DESC_COUNT)) u_table (
        .clk(clk), .rst(rst),
        .h_we(hw_en), .h_waddr(hw_addr), .h_wdata(hw_data),
        .h_raddr(hr_addr), .h_rdata(hr_data),
        .t_idx(tx_idx), .t_we(t_we), .t_wdata(t_upd), .t_lf(t_lf_w), .t_ptr(tx_ptr),
        .r_idx(rx_idx), .r_we(r_we), .r_wdata(r_upd), .r_lf(r_lf_w), .r_ptr(rx_ptr)
    );

    bdr_tx_ctrl #(.DESC_COUNT(DESC_COUNT)) u_tx (
        .clk(clk), .rst(rst), .txen(txen), .table_wr(hw_en), .tx_done(tx_done),
        .boundary(boundary), .cur_lf(t_lf), .idx(tx_idx), .start(tx_start),
        .upd_we(t_we), .upd_lf(t_upd), .done_set(t_irq)
    );

    bdr_rx_ctrl #(.DESC_COUNT(DESC_COUNT)) u_rx (
        .clk(clk), .rst(rst), .rxen(rxen), .rx_req(rx_req), .rx_len(rx_len),
        .boundary(boundary), .cur_lf(r_lf), .idx(rx_idx),
        .upd_we(r_we), .upd_lf(r_upd), .done_set(r_irq), .busy_set(r_busy)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[SRC_TX]   = t_irq;
        set_vec[SRC_RX]   = r_irq;
        set_vec[SRC_BUSY] = r_busy;
    end

    bdr_irq u_irq (
        .clk(clk), .rst(rst), .set_vec(set_vec),
        .clr_we(cfg_we && sel == CFG_SRC_CLR), .clr_vec(cfg_wdata[SRC_W-1:0]),
        .mask_we(cfg_we && sel == CFG_MASK), .mask_val(cfg_wdata[SRC_W-1:0]),
        .src(int_src), .mask(int_mask), .irq(irq)
    );
endmodule

// File: rtl/bdr_checker.sv
module bdr_checker #(
    parameter int DESC_COUNT = 128,
    localparam int IDX_W = $clog2(DESC_COUNT),
    localparam int BND_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             txen,
    input logic             rxen,
    input logic             cfg_we,
    input logic [1:0]       cfg_sel,
    input logic [31:0]      cfg_wdata,
    input logic             tx_start,
    input logic             tx_done,
    input logic             rx_req,
    input logic [BND_W-1:0] boundary,
    input logic [IDX_W-1:0] tx_idx,
    input logic [IDX_W-1:0] rx_idx,
    input logic [4:0]       int_src
);
    a_r2_boundary_range: assert property (@(posedge clk) disable iff (rst)
        boundary < BND_W'(DESC_COUNT));

    a_r3_start_enabled: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> ($past(txen) && $past(boundary) != '0));

    a_r4_single_start: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    a_r10_w1c: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd1 && !tx_done && !rx_req)
        |=> ((int_src & $past(cfg_wdata[4:0])) == 5'd0));

    a_r11_tx_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(txen) |=> tx_idx == '0);

    a_r11_rx_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(rxen) |=> rx_idx == $past(boundary[IDX_W-1:0]));

    a_r12_rx_off: assert property (@(posedge clk) disable iff (rst)
        !rxen |=> rx_idx == $past(rx_idx));
endmodule

bind bd_ring_ctrl bdr_checker #(.DESC_COUNT(DESC_COUNT)) u_chk (
    .clk(clk), .rst(rst), .txen(txen), .rxen(rxen), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .tx_start(tx_start),
    .tx_done(tx_done), .rx_req(rx_req), .boundary(boundary),
    .tx_idx(tx_idx), .rx_idx(rx_idx), .int_src(int_src)
);

// File: tb/sim_bd_ring_ctrl.sv
`timescale 1ns/1ps
module sim_bd_ring_ctrl;
    logic clk = 1'b0, rst = 1'b1, txen = 1'b0, rxen = 1'b0;
    logic hw_en = 1'b0, cfg_we = 1'b0, tx_done = 1'b0, rx_req = 1'b0;
    logic [7:0] hw_addr = '0, hr_addr = '0;
    logic [31:0] hw_data = '0, cfg_wdata = '0, hr_data, tx_ptr, rx_ptr;
    logic [1:0] cfg_sel = '0;
    logic [7:0] boundary;
    logic [4:0] int_src, int_mask;
    logic irq, tx_start;
    logic [6:0] tx_idx, rx_idx;
    logic [15:0] tx_len, rx_len = '0;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bd_ring_ctrl u0 (.*);

    // Transmit vectors: flags word of descriptor 0, start expected,
    // word after retire, index after retire, tx source bit expected
    localparam int NV = 7;
    localparam logic [31:0] V_LF [NV] = '{32'h0040_8000, 32'h0004_8000, 32'h0005_C1FF,
        32'h0040_0000, 32'h0100_A0F0, 32'h0200_8E00, 32'hFFFF_E0FF};
    localparam bit V_GO [NV] = '{1, 0, 1, 0, 1, 1, 1};
    localparam logic [31:0] V_AFT [NV] = '{32'h0040_0000, 32'h0004_8000, 32'h0005_4000,
        32'h0040_0000, 32'h0100_2000, 32'h0200_0E00, 32'hFFFF_6000};
    localparam logic [6:0] V_IDX [NV] = '{7'd1, 7'd0, 7'd1, 7'd0, 7'd0, 7'd1, 7'd0};
    localparam bit V_IRQ [NV] = '{0, 0, 1, 0, 0, 0, 1};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); hw_en = 1; hw_addr = a; hw_data = d;
        @(negedge clk); hw_en = 0;
    endtask

    task automatic cfg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic rx_frame(input logic [15:0] len);
        @(negedge clk); rx_req = 1; rx_len = len;
        @(negedge clk); rx_req = 0;
    endtask

    task automatic retire();
        tx_done = 1;
        @(negedge clk); tx_done = 0;
    endtask

    // drop and raise txen, then sample in the cycle a start would appear
    task automatic tx_kick();
        @(negedge clk); txen = 0;
        @(negedge clk); txen = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        eq("R1 boundary", 32'(boundary), 32'h40);
        eq("R1 tx_idx", 32'(tx_idx), 0);
        eq("R1 rx_idx", 32'(rx_idx), 32'h40);
        eq("R1 int_src", 32'(int_src), 0);
        eq("R1 int_mask", 32'(int_mask), 0);
        eq("R1 irq", 32'(irq), 0);
        hr_addr = 8'h81; #1;
        eq("R1 table word", hr_data, 0);

        // R2 boundary range
        cfg(2'd0, 32'h80);  eq("R2 0x80 ignored", 32'(boundary), 32'h40);
        cfg(2'd0, 32'h1FF); eq("R2 0x1FF ignored", 32'(boundary), 32'h40);
        cfg(2'd0, 32'h7F);  eq("R2 0x7F taken", 32'(boundary), 32'h7F);

        // R3 no start with empty transmit ring
        cfg(2'd0, 32'h0);
        hwrite(8'h00, 32'h000A_8000);
        tx_kick();
        eq("R3 N=0 no start", 32'(tx_start), 0);
        cfg(2'd0, 32'h40);

        // Vector loop over descriptor 0
        for (int i = 0; i < NV; i++) begin
            @(negedge clk); txen = 0;
            hwrite(8'h00, V_LF[i]);
            hwrite(8'h01, 32'h1000_0000 + 32'(i));
            @(negedge clk);
            eq("R3 no start while txen low", 32'(tx_start), 0);
            @(negedge clk); txen = 1;
            @(negedge clk);
            eq("R11 tx_idx zero after txen rise", 32'(tx_idx), 0);
            @(negedge clk);
            eq("R3 start decision", 32'(tx_start), 32'(V_GO[i]));
            if (V_GO[i]) begin
                eq("R3 tx_len", 32'(tx_len), 32'(V_LF[i][31:16]));
                eq("R3 tx_ptr", tx_ptr, 32'h1000_0000 + 32'(i));
                retire();
                eq("R4 single start", 32'(tx_start), 0);
                hr_addr = 8'h00; #1;
                eq("R5 retired word", hr_data, V_AFT[i]);
                eq("R6 tx_idx after retire", 32'(tx_idx), 32'(V_IDX[i]));
                eq("R9 tx source", 32'(int_src[0]), 32'(V_IRQ[i]));
                cfg(2'd1, 32'h1F);
            end else begin
                @(negedge clk);
                eq("R3 still idle", 32'(tx_start), 0);
            end
        end

        // R6 ring wrap at N, and no start without a trigger
        @(negedge clk); txen = 0;
        cfg(2'd0, 32'h2);
        hwrite(8'h00, 32'h000A_8000);
        hwrite(8'h02, 32'h000B_8000);
        tx_kick();
        eq("R3 start desc0", 32'(tx_start), 1);
        retire();
        eq("R6 idx 1", 32'(tx_idx), 1);
        @(negedge clk); @(negedge clk);
        eq("R3 no start without trigger", 32'(tx_start), 0);
        hwrite(8'h03, 32'h2222_0000);
        @(negedge clk);
        eq("R3 start after write", 32'(tx_start), 1);
        eq("R3 tx_ptr desc1", tx_ptr, 32'h2222_0000);
        retire();
        eq("R6 wrap at N", 32'(tx_idx), 0);

        // Receive ring near the table end
        cfg(2'd0, 32'h7D);
        hwrite(8'hFA, 32'h0000_81FF);
        hwrite(8'hFC, 32'h0000_C000);
        hwrite(8'hFE, 32'h0000_8000);
        rx_frame(16'h20);
        eq("R12 rx_idx unchanged", 32'(rx_idx), 32'h40);
        eq("R12 src unchanged", 32'(int_src), 0);
        hr_addr = 8'h80; #1;
        eq("R12 table unchanged", hr_data, 0);
        @(negedge clk); rxen = 1;
        @(negedge clk);
        eq("R11 rx_idx to N", 32'(rx_idx), 32'h7D);
        rx_frame(16'h3C);
        hr_addr = 8'hFA; #1;
        eq("R8 filled word", hr_data, 32'h003C_0000);
        eq("R8 idx inc", 32'(rx_idx), 32'h7E);
        eq("R9 no rx source", 32'(int_src), 0);
        rx_frame(16'h100);
        hr_addr = 8'hFC; #1;
        eq("R8 filled word irq", hr_data, 32'h0100_4000);
        eq("R9 rx source", 32'(int_src), 32'h02);
        eq("R8 idx 127", 32'(rx_idx), 32'h7F);
        rx_frame(16'h40);
        hr_addr = 8'hFE; #1;
        eq("R8 last word", hr_data, 32'h0040_0000);
        eq("R8 idx back to N", 32'(rx_idx), 32'h7D);
        rx_frame(16'h55);
        hr_addr = 8'hFA; #1;
        eq("R7 drop keeps word", hr_data, 32'h003C_0000);
        eq("R7 drop keeps idx", 32'(rx_idx), 32'h7D);
        eq("R7 busy source", 32'(int_src), 32'h12);
        hwrite(8'hFA, 32'h0000_A000);
        rx_frame(16'h11);
        hr_addr = 8'hFA; #1;
        eq("R8 wrap word", hr_data, 32'h0011_2000);
        eq("R8 wrap idx", 32'(rx_idx), 32'h7D);

        // R10 mask and write-1-to-clear
        eq("R10 irq masked", 32'(irq), 0);
        cfg(2'd2, 32'h02);
        eq("R10 irq on", 32'(irq), 1);
        cfg(2'd1, 32'h02);
        eq("R10 clear one bit", 32'(int_src), 32'h10);
        eq("R10 irq off", 32'(irq), 0);
        cfg(2'd2, 32'h12);
        eq("R10 irq busy", 32'(irq), 1);
        cfg(2'd1, 32'h10);
        eq("R10 all clear", 32'(int_src), 0);
        eq("R10 irq low", 32'(irq), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule